// File: doc/BRIEF.md
# Write Leveling Sequencer

This block runs the write leveling loop for one memory device on the controller side. When `start` arrives, it first loads a starting strobe delay tap. It then issues a mode register write that sets the leveling enable bit and waits for the command port to accept it. After that it repeats a probe cycle: it requests one burst of strobe pulses and waits a programmable number of cycles so that the device has time to return its result. It then reads the single data bit the device sent back. That bit is the level of the memory clock as the device saw it on the strobe edge.

A returned 0 means the strobe is early, so the tap steps up. A returned 1 means it is late, so the tap steps down. The loop ends at the first tap that reads 1 directly next to a tap that read 0. That tap is locked whichever direction the search was moving. If the tap counter reaches its top while the device still reads 0, or reaches zero while it still reads 1, the search fails and an error flag is raised. In both cases a second mode register write clears the leveling enable bit, and `done` pulses for one cycle.

The states are IDLE, ENTER, FIRE, SETTLE, JUDGE, EXIT and DONE. The transitions are:
- IDLE→ENTER on `start`.
- ENTER→FIRE on `mrs_ack`.
- FIRE→JUDGE when the wait count is zero.
- FIRE→SETTLE when the wait count is not zero.
- SETTLE→JUDGE on the last wait cycle.
- JUDGE→FIRE after a step up or a step down.
- JUDGE→EXIT on a lock or a failure.
- EXIT→DONE on `mrs_ack`.
- DONE→IDLE always.

Top module: `wlvl_seq`

## Requirements
- R1: After reset, `mrs_req`, `burst_req`, `done` and `err` are 0 and `tap_out` is 0.
- R2: A `start` seen in IDLE loads `tap_init` into `tap_out`. It then raises `mrs_req` with `mrs_sel` = 1 and `mrs_val` = `mr1_base` with bit 7 forced to 1. Both are held unchanged until the cycle in which `mrs_ack` is high.
- R3: Each probe raises `burst_req` for exactly one cycle.
- R4: The returned bit `dq_sample` is taken exactly `wait_cycles`+1 cycles after the `burst_req` cycle. The value it has in any earlier cycle has no effect.
- R5: A sample of 0 raises the tap by one, and a sample of 1 lowers it by one. The next burst uses the new tap.
- R6: The sequence locks at the first tap that reads 1 next to a tap that read 0. When stepping up, this is the tap just sampled. When stepping down, it is the tap one above.
- R7: A sample of 0 at the top tap (all ones), or a sample of 1 at tap 0, with no opposite reading before it, sets `err` and ends the search. `tap_out` stays at that limit.
- R8: At the end, `mrs_req` is raised with `mrs_val` = `mr1_base` with bit 7 forced to 0. After the ack, `done` is high for exactly one cycle. `err` holds until the next accepted `start`.
- R9: A `start` seen outside IDLE is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a leveling run (accepted in IDLE) |
| tap_init | input | TAP_W | First tap tried |
| wait_cycles | input | WAIT_W | Idle cycles after each burst before sampling |
| mr1_base | input | MR_W | Mode register contents to which the enable bit is applied |
| mrs_req | output | 1 | Mode register write request |
| mrs_ack | input | 1 | Command port accepted the write |
| mrs_sel | output | 3 | Mode register index (1) |
| mrs_val | output | MR_W | Mode register value |
| burst_req | output | 1 | One-cycle request for a strobe burst |
| dq_sample | input | 1 | Clock level returned by the device |
| tap_out | output | TAP_W | Strobe delay tap |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No transition found before a tap limit |

## Verification
The device model in the bench drives the inverse of the correct reply right after each burst. It switches to the correct reply only in the last cycle before sampling is due. A sequencer that sampled one cycle early would therefore walk in the wrong direction and report a different tap and burst count. The runs search upward and downward, start exactly on the edge, start at tap 0 and at the top tap, and hit both limits. An off-by-one lock or a wrapping counter would show up there as a wrong tap, a wrong burst count or a missing error. A second start in the middle of a run, and mode register bases whose bit 7 is already set, show whether the sequencer restarts when it should not or fails to force the enable bit.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENTER,
        S_FIRE,
        S_SETTLE,
        S_JUDGE,
        S_EXIT,
        S_DONE
    } wl_state_t;

    typedef enum logic [2:0] {
        ACT_UP,
        ACT_DOWN,
        ACT_LOCK_HERE,
        ACT_LOCK_ABOVE,
        ACT_FAIL
    } wl_act_t;

endpackage

// File: rtl/wlvl_tap.sv
module wlvl_tap #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TAP_W-1:0] load_val,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [TAP_W-1:0] tap,
    output logic             at_max,
    output logic             at_min
);
    localparam logic [TAP_W-1:0] TAP_TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap <= '0;
        end else if (load) begin
            tap <= load_val;
        end else if (step_up) begin
            tap <= tap + 1'b1;
        end else if (step_dn) begin
            tap <= tap - 1'b1;
        end
    end

    assign at_max = (tap == TAP_TOP);
    assign at_min = (tap == '0);

    // R5: one step per judged sample
    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !load) |=> (tap == TAP_W'($past(tap) + 1'b1)));
    a_r5_step_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !load) |=> (tap == TAP_W'($past(tap) - 1'b1)));
    // R7: the controller never asks for a wrapping step
    a_r7_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |-> !at_max);
    a_r7_no_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn |-> !at_min);

endmodule

// File: rtl/wlvl_timer.sv
module wlvl_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              last
);
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt <= WAIT_W'(1));

endmodule

// File: rtl/wlvl_judge.sv
module wlvl_judge
    import wlvl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    update,
    input  logic    sample,
    input  logic    at_max,
    input  logic    at_min,
    output wl_act_t act
);
    logic have_prev;
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev      <= 1'b0;
        end else if (clear) begin
            have_prev <= 1'b0;
            prev      <= 1'b0;
        end else if (update) begin
            have_prev <= 1'b1;
            prev      <= sample;
        end
    end

    always_comb begin
        act = ACT_UP;
        if (!sample) begin
            if (have_prev && prev)      act = ACT_LOCK_ABOVE;
            else if (at_max)            act = ACT_FAIL;
            else                        act = ACT_UP;
        end else begin
            if (have_prev && !prev)     act = ACT_LOCK_HERE;
            else if (at_min)            act = ACT_FAIL;
            else                        act = ACT_DOWN;
        end
    end

endmodule

// File: rtl/wlvl_seq.sv
module wlvl_seq
    import wlvl_pkg::*;
#(
    parameter int TAP_W   = 6,
    parameter int WAIT_W  = 8,
    parameter int MR_W    = 16,
    parameter int LVL_BIT = 7,
    parameter int MR_SEL  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAP_W-1:0]  tap_init,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic [MR_W-1:0]   mr1_base,
    output logic              mrs_req,
    input  logic              mrs_ack,
    output logic [2:0]        mrs_sel,
    output logic [MR_W-1:0]   mrs_val,
    output logic              burst_req,
    input  logic              dq_sample,
    output logic [TAP_W-1:0]  tap_out,
    output logic              done,
    output logic              err
);
    localparam logic [MR_W-1:0] LVL_MASK = MR_W'(1) << LVL_BIT;
    localparam logic [2:0]      SEL_VAL  = 3'(MR_SEL);

    wl_state_t state, state_nx;
    wl_act_t   act;

    logic tap_load, step_up, step_dn;
    logic tap_at_max, tap_at_min;
    logic timer_load, timer_run, timer_last;
    logic judge_now;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_ENTER;
            S_ENTER:  if (mrs_ack) state_nx = S_FIRE;
            S_FIRE:   state_nx = (wait_cycles == '0) ? S_JUDGE : S_SETTLE;
            S_SETTLE: if (timer_last) state_nx = S_JUDGE;
            S_JUDGE:  state_nx = (act == ACT_UP || act == ACT_DOWN) ? S_FIRE : S_EXIT;
            S_EXIT:   if (mrs_ack) state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // ---------------- datapath controls ----------------
    always_comb begin
        tap_load   = (state == S_IDLE) && start;
        timer_load = (state == S_FIRE);
        timer_run  = (state == S_SETTLE);
        judge_now  = (state == S_JUDGE);
        step_up    = judge_now && (act == ACT_UP || act == ACT_LOCK_ABOVE);
        step_dn    = judge_now && (act == ACT_DOWN);
    end

    // ---------------- outputs ----------------
    always_comb begin
        mrs_req   = (state == S_ENTER) || (state == S_EXIT);
        mrs_sel   = SEL_VAL;
        mrs_val   = (state == S_ENTER) ? (mr1_base | LVL_MASK) : (mr1_base & ~LVL_MASK);
        burst_req = (state == S_FIRE);
        done      = (state == S_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           err <= 1'b0;
        else if (tap_load)                    err <= 1'b0;
        else if (judge_now && act == ACT_FAIL) err <= 1'b1;
    end

    // ---------------- sub-blocks ----------------
    wlvl_tap #(.TAP_W(TAP_W)) u_tap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tap_load),
        .load_val (tap_init),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .tap      (tap_out),
        .at_max   (tap_at_max),
        .at_min   (tap_at_min)
    );

    wlvl_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (wait_cycles),
        .run      (timer_run),
        .last     (timer_last)
    );

    wlvl_judge u_judge (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tap_load),
        .update (judge_now),
        .sample (dq_sample),
        .at_max (tap_at_max),
        .at_min (tap_at_min),
        .act    (act)
    );

    // ---------------- assertions ----------------
    // R2 / R8: a pending mode register write is held steady
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_req && !mrs_ack) |=> (mrs_req && $stable(mrs_val) && $stable(mrs_sel)));
    // R3: strobe burst request lasts one cycle
    a_r3_burst_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |=> !burst_req);
    // R4: no judgment while the wait counter still has cycles left
    a_r4_wait_honoured: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SETTLE && !timer_last) |=> (state == S_SETTLE));
    // R7: error only rises at a tap limit
    a_r7_err_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (tap_at_max || tap_at_min));
    // R8: completion pulse is one cycle and follows an accepted exit write
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_exit_first: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mrs_req && mrs_ack && !mrs_val[LVL_BIT]));
    // R9: no reload of the tap while busy
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == S_ENTER && !mrs_ack) |=> $stable(tap_out));

endmodule

// File: tb/wlvl_seq_tb.sv
module wlvl_seq_tb;
    localparam int TAP_W  = 6;
    localparam int WAIT_W = 8;
    localparam int MR_W   = 16;
    localparam int TOP    = (1 << TAP_W) - 1;

    typedef struct {
        int tap;
        int err;
        int bursts;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [TAP_W-1:0]  tap_init = '0;
    logic [WAIT_W-1:0] wait_cycles = '0;
    logic [MR_W-1:0]   mr1_base = 16'h0A45;
    logic              mrs_req;
    logic              mrs_ack = 1'b0;
    logic [2:0]        mrs_sel;
    logic [MR_W-1:0]   mrs_val;
    logic              burst_req;
    logic              dq = 1'b0;
    logic [TAP_W-1:0]  tap_out;
    logic              done;
    logic              err;

    int total = 0;
    int bad = 0;
    exp_t q[$];
    int edge_tap = 0;
    int dcnt = 0;
    int burst_cnt = 0;
    int mrs_wait = 0;
    bit mrs_exit_phase = 0;
    bit pending = 0;
    bit done_seen_prev = 0;

    always #5 clk = ~clk;

    wlvl_seq #(.TAP_W(TAP_W), .WAIT_W(WAIT_W), .MR_W(MR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tap_init(tap_init),
        .wait_cycles(wait_cycles), .mr1_base(mr1_base), .mrs_req(mrs_req),
        .mrs_ack(mrs_ack), .mrs_sel(mrs_sel), .mrs_val(mrs_val),
        .burst_req(burst_req), .dq_sample(dq), .tap_out(tap_out),
        .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device model: wrong reply until the sample is due (R4)
    always @(negedge clk) begin
        if (burst_req) begin
            dcnt = int'(wait_cycles) + 1;
            dq   = !(int'(tap_out) >= edge_tap);
        end else if (dcnt > 0) begin
            dcnt--;
            if (dcnt == 0) dq = (int'(tap_out) >= edge_tap);
        end
    end

    // command port responder, checks R2 and R8 values
    always @(negedge clk) begin
        if (mrs_ack) begin
            mrs_ack = 1'b0;
            mrs_wait = 0;
        end else if (mrs_req) begin
            mrs_wait++;
            if (mrs_wait == 2) begin
                logic [MR_W-1:0] expv;
                expv = mrs_exit_phase ? (mr1_base & ~16'h0080) : (mr1_base | 16'h0080);
                check(mrs_val == expv, mrs_exit_phase ? "R8 exit value" : "R2 enter value",
                      int'(mrs_val), int'(expv));
                check(mrs_sel == 3'd1, "R2 register index", int'(mrs_sel), 1);
                mrs_exit_phase = !mrs_exit_phase;
                mrs_ack = 1'b1;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_seen_prev)
                check(!done, "R8 done one cycle", int'(done), 0);
            done_seen_prev = done;
            if (burst_req) burst_cnt++;
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R6 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(int'(tap_out) == e.tap, "R6/R7 final tap (R4 R5 path)", int'(tap_out), e.tap);
                    check(int'(err) == e.err, "R7 error flag", int'(err), e.err);
                    check(burst_cnt == e.bursts, "R3/R5 burst count", burst_cnt, e.bursts);
                end
                burst_cnt = 0;
                pending = 0;
            end
        end
    end

    function automatic exp_t model(input int s, input int e);
        exp_t r;
        if (e == 0) begin
            r.tap = 0; r.err = 1; r.bursts = s + 1;
        end else if (e > TOP) begin
            r.tap = TOP; r.err = 1; r.bursts = TOP - s + 1;
        end else if (s >= e) begin
            r.tap = e; r.err = 0; r.bursts = s - e + 2;
        end else begin
            r.tap = e; r.err = 0; r.bursts = e - s + 1;
        end
        return r;
    endfunction

    // driver
    task automatic run(input int s, input int e, input int w, input bit poke);
        @(negedge clk);
        edge_tap    = e;
        tap_init    = TAP_W'(s);
        wait_cycles = WAIT_W'(w);
        q.push_back(model(s, e));
        pending = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            tap_init = TAP_W'(40);
            start = 1'b1;          // R9: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (pending) @(negedge clk);
        if (e != 0 && e <= TOP)
            check(!err, "R8 err cleared by new start", int'(err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!mrs_req && !burst_req, "R1 idle requests", int'({mrs_req, burst_req}), 0);
        check(!done && !err, "R1 flags", int'({done, err}), 0);
        check(tap_out == '0, "R1 tap", int'(tap_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(10, 20, 3, 0);     // upward search
        run(30, 12, 0, 0);     // downward search, no wait
        run(5, 0, 2, 0);       // R7 lower limit
        run(0, 1, 5, 0);       // upward from tap 0
        run(60, 70, 1, 0);     // R7 upper limit
        run(7, 7, 4, 0);       // starts on edge
        mr1_base = 16'h1F81;
        run(63, 63, 2, 0);     // top tap is the edge
        run(10, 20, 3, 1);     // R9 start while busy
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule